// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Command Decoder

This block takes complete 16-bit command words from a serial front end and turns them into register actions on two converter channels, A and B. Each channel holds a staging (input) register and an output register of 13 bits. Staging and output can be written separately or together, so both channels can be made to change output on the same clock edge. The block also holds a shutdown state for each channel, a general-purpose logic output and the bit that picks the edge on which the daisy-chain output shifts.

The three most significant bits of a word form the command field. The low 13 bits carry data. When the command field is zero, bits 12..10 of the data act as an extended command and bit 9 is an argument. Shutdown requests take effect only while the lockout input is high. Pulling the lockout input low wakes both channels at once, without waiting for a clock, and each channel keeps its previous output code.

Top module: `dac_cmd_decoder`

## Requirements
- R1: After reset (`rst_ni` low, asynchronous) or a sampled low on `clr_ni` (synchronous, and it takes priority over a word strobed in the same cycle), both staging and output registers are zero, `upo_o` is 0, `dout_mode_o` is 0 and `active_o` is 2'b11.
- R2: A valid word with command field (bits 15..13) 3'b001 writes data bits 12..0 into staging A. Field 3'b101 writes them into staging B. Neither field changes any output register.
- R3: Field 3'b010 writes staging A and field 3'b110 writes staging B. In the same step, both output registers copy their staging registers, including the new value.
- R4: Field 3'b011 writes the data into the staging and output registers of both channels.
- R5: Field 3'b100 copies each staging register into its output register.
- R6: Field 3'b111 shuts down both channels (`active_o` = 2'b00) when `pdl_i` is high. All register contents are kept.
- R7: With field 3'b000, extended code (bits 12..10) 3'b001 copies staging A to output A and 3'b101 copies staging B to output B. Any transfer into a channel's output register makes that channel active again. `active_o[0]` is channel A.
- R8: With field 3'b000, extended code 3'b110 shuts down channel A and 3'b111 shuts down channel B, each only when `pdl_i` is high.
- R9: With field 3'b000, extended code 3'b011 sets `upo_o` to 1 and 3'b010 sets it to 0.
- R10: With field 3'b000, extended code 3'b100 loads `dout_mode_o` from bit 9. A value of 1 means shifting on the rising edge and 0 means the falling edge.
- R11: Extended code 3'b000 has no effect. A word presented while `word_valid_i` is low also has no effect.
- R12: While `pdl_i` is low, shutdown commands are ignored and `active_o` reads 2'b11 with no clock needed. The shutdown state is cleared at the next clock edge, so channels stay active when `pdl_i` returns high.
- R13: Every result of a valid word is visible on the outputs after the one clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 16 | Command word: field in 15..13, data in 12..0 |
| word_valid_i | input | 1 | Word strobe, one cycle per word |
| clr_ni | input | 1 | Synchronous clear, active low |
| pdl_i | input | 1 | Shutdown lockout; low blocks and cancels shutdown |
| out_a_o | output | 13 | Output register of channel A |
| out_b_o | output | 13 | Output register of channel B |
| active_o | output | 2 | Per-channel active flags, bit 0 = A |
| upo_o | output | 1 | General-purpose logic output |
| dout_mode_o | output | 1 | Daisy-chain shift edge select |

## Verification
Each register result of a strobed word or a clear is due after exactly one edge. The bench drives on the falling edge, and the monitor compares the outputs at the next falling edge against the expected snapshot queued by the driver. The wake from the lockout input has no register in its path, so it is checked one time step after `pdl_i` falls, before any clock edge. The clearing of the shutdown state is checked again after `pdl_i` rises.

// File: rtl/dcd_pkg.sv
`timescale 1ns/1ps
package dcd_pkg;
  parameter int unsigned DATA_W = 13;
  parameter int unsigned CMD_W  = 3;
  parameter int unsigned NUM_CH = 2;
  localparam int unsigned WORD_W = DATA_W + CMD_W;
  localparam int unsigned EXT_W  = 3;
  localparam int unsigned ARG_BIT = DATA_W - EXT_W - 1;

  typedef enum logic [CMD_W-1:0] {
    F_EXT      = 3'b000,
    F_LD_A     = 3'b001,
    F_LD_A_UPD = 3'b010,
    F_LD_BOTH  = 3'b011,
    F_XFER     = 3'b100,
    F_LD_B     = 3'b101,
    F_LD_B_UPD = 3'b110,
    F_SD_BOTH  = 3'b111
  } field_e;

  typedef enum logic [EXT_W-1:0] {
    X_NOP    = 3'b000,
    X_XFER_A = 3'b001,
    X_UPO_LO = 3'b010,
    X_UPO_HI = 3'b011,
    X_MODE   = 3'b100,
    X_XFER_B = 3'b101,
    X_SD_A   = 3'b110,
    X_SD_B   = 3'b111
  } ext_e;

  typedef struct packed {
    logic [NUM_CH-1:0] ld_in;
    logic [NUM_CH-1:0] xfer;
    logic [NUM_CH-1:0] sd;
    logic              upo_we;
    logic              upo_val;
    logic              mode_we;
    logic              mode_val;
  } act_t;
endpackage

// File: rtl/dcd_decode.sv
`timescale 1ns/1ps
module dcd_decode
  import dcd_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  input  logic              pdl_i,
  output act_t              act_o
);
  field_e field;
  ext_e   ext;

  assign field = field_e'(word_i[WORD_W-1 -: CMD_W]);
  assign ext   = ext_e'(word_i[DATA_W-1 -: EXT_W]);

  always_comb begin
    act_o = '0;
    act_o.upo_val  = (ext == X_UPO_HI);
    act_o.mode_val = word_i[ARG_BIT];
    if (valid_i) begin
      unique case (field)
        F_LD_A:     act_o.ld_in[0] = 1'b1;
        F_LD_B:     act_o.ld_in[1] = 1'b1;
        F_LD_A_UPD: begin act_o.ld_in[0] = 1'b1; act_o.xfer = '1; end
        F_LD_B_UPD: begin act_o.ld_in[1] = 1'b1; act_o.xfer = '1; end
        F_LD_BOTH:  begin act_o.ld_in = '1; act_o.xfer = '1; end
        F_XFER:     act_o.xfer = '1;
        F_SD_BOTH:  act_o.sd = {NUM_CH{pdl_i}};
        F_EXT: begin
          unique case (ext)
            X_XFER_A: act_o.xfer[0] = 1'b1;
            X_XFER_B: act_o.xfer[1] = 1'b1;
            X_SD_A:   act_o.sd[0]   = pdl_i;
            X_SD_B:   act_o.sd[1]   = pdl_i;
            X_UPO_LO, X_UPO_HI: act_o.upo_we = 1'b1;
            X_MODE:   act_o.mode_we = 1'b1;
            default:  ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dcd_chan.sv
`timescale 1ns/1ps
module dcd_chan
  import dcd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ld_i,
  input  logic              xfer_i,
  input  logic              sd_i,
  input  logic              pdl_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] out_o,
  output logic              active_o
);
  logic [DATA_W-1:0] in_q, in_nxt, out_q;
  logic              sd_q;

  assign in_nxt = ld_i ? data_i : in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      out_q <= '0;
      sd_q  <= 1'b0;
    end else if (clr_i) begin
      in_q  <= '0;
      out_q <= '0;
      sd_q  <= 1'b0;
    end else begin
      in_q <= in_nxt;
      if (xfer_i) begin
        out_q <= in_nxt;
        sd_q  <= 1'b0;
      end else if (sd_i) begin
        sd_q <= 1'b1;
      end else if (!pdl_i) begin
        sd_q <= 1'b0;
      end
    end
  end

  // lockout low wakes without a clock
  assign active_o = ~(sd_q & pdl_i);
  assign out_o    = out_q;
endmodule

// File: rtl/dac_cmd_decoder.sv
`timescale 1ns/1ps
module dac_cmd_decoder
  import dcd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  input  logic              clr_ni,
  input  logic              pdl_i,
  output logic [DATA_W-1:0] out_a_o,
  output logic [DATA_W-1:0] out_b_o,
  output logic [NUM_CH-1:0] active_o,
  output logic              upo_o,
  output logic              dout_mode_o
);
  act_t              act;
  logic [DATA_W-1:0] ch_out [NUM_CH];
  logic              upo_q, mode_q;

  dcd_decode u_dec (
    .word_i  (word_i),
    .valid_i (word_valid_i),
    .pdl_i   (pdl_i),
    .act_o   (act)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dcd_chan u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (~clr_ni),
      .ld_i     (act.ld_in[c]),
      .xfer_i   (act.xfer[c]),
      .sd_i     (act.sd[c]),
      .pdl_i    (pdl_i),
      .data_i   (word_i[DATA_W-1:0]),
      .out_o    (ch_out[c]),
      .active_o (active_o[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upo_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (!clr_ni) begin
      upo_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (act.upo_we)  upo_q  <= act.upo_val;
      if (act.mode_we) mode_q <= act.mode_val;
    end
  end

  assign out_a_o     = ch_out[0];
  assign out_b_o     = ch_out[1];
  assign upo_o       = upo_q;
  assign dout_mode_o = mode_q;
endmodule

// File: rtl/dcd_checker.sv
`timescale 1ns/1ps
module dcd_checker
  import dcd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] word_i,
  input logic              word_valid_i,
  input logic              clr_ni,
  input logic              pdl_i,
  input logic [DATA_W-1:0] out_a_o,
  input logic [DATA_W-1:0] out_b_o,
  input logic [NUM_CH-1:0] active_o,
  input logic              upo_o,
  input logic              dout_mode_o
);
  logic [CMD_W-1:0] fld;
  logic [EXT_W-1:0] ext;
  logic             go;
  assign fld = word_i[WORD_W-1 -: CMD_W];
  assign ext = word_i[DATA_W-1 -: EXT_W];
  assign go  = word_valid_i && clr_ni;

  // R2
  ld_only_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && (fld == 3'b001 || fld == 3'b101) |=> $stable(out_a_o) && $stable(out_b_o));

  // R3
  ld_upd_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && fld == 3'b010 |=> out_a_o == $past(word_i[DATA_W-1:0]));

  // R4
  ld_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && fld == 3'b011 |=> out_a_o == $past(word_i[DATA_W-1:0])
                         && out_b_o == $past(word_i[DATA_W-1:0]));

  // R6
  sd_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && fld == 3'b111 && pdl_i |=> (!pdl_i || active_o == 2'b00));

  // R9
  upo_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && fld == 3'b000 && ext == 3'b011 |=> upo_o);

  // R12
  lockout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdl_i |-> active_o == 2'b11);

  // R1
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> out_a_o == '0 && out_b_o == '0 && !upo_o && !dout_mode_o);
endmodule

bind dac_cmd_decoder dcd_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_i       (word_i),
  .word_valid_i (word_valid_i),
  .clr_ni       (clr_ni),
  .pdl_i        (pdl_i),
  .out_a_o      (out_a_o),
  .out_b_o      (out_b_o),
  .active_o     (active_o),
  .upo_o        (upo_o),
  .dout_mode_o  (dout_mode_o)
);

// File: tb/tb_dac_cmd_decoder.sv
`timescale 1ns/1ps
module tb_dac_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] word = '0;
  logic        valid = 1'b0;
  logic        clr_n = 1'b1;
  logic        pdl = 1'b1;
  logic [12:0] out_a, out_b;
  logic [1:0]  active;
  logic        upo, mode;

  always #10 clk = ~clk;

  dac_cmd_decoder dut (
    .clk_i(clk), .rst_ni(rst_ni), .word_i(word), .word_valid_i(valid),
    .clr_ni(clr_n), .pdl_i(pdl), .out_a_o(out_a), .out_b_o(out_b),
    .active_o(active), .upo_o(upo), .dout_mode_o(mode)
  );

  typedef struct {
    logic [12:0] a, b;
    logic [1:0]  act;
    logic        upo, mode;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int n_vec = 0, n_bad = 0;

  logic [12:0] m_in [2];
  logic [12:0] m_out[2];
  logic [1:0]  m_sd;
  logic        m_upo, m_mode;

  function automatic void model_clear();
    for (int i = 0; i < 2; i++) begin m_in[i] = '0; m_out[i] = '0; end
    m_sd = '0; m_upo = 1'b0; m_mode = 1'b0;
  endfunction

  function automatic void xfer(int i);
    m_out[i] = m_in[i];
    m_sd[i]  = 1'b0;
  endfunction

  function automatic void model_apply(logic [15:0] w);
    logic [12:0] d = w[12:0];
    case (w[15:13])
      3'b001: m_in[0] = d;
      3'b101: m_in[1] = d;
      3'b010: begin m_in[0] = d; xfer(0); xfer(1); end
      3'b110: begin m_in[1] = d; xfer(0); xfer(1); end
      3'b011: begin m_in[0] = d; m_in[1] = d; xfer(0); xfer(1); end
      3'b100: begin xfer(0); xfer(1); end
      3'b111: if (pdl) m_sd = 2'b11;
      default: case (w[12:10])
        3'b001: xfer(0);
        3'b101: xfer(1);
        3'b110: if (pdl) m_sd[0] = 1'b1;
        3'b111: if (pdl) m_sd[1] = 1'b1;
        3'b010: m_upo = 1'b0;
        3'b011: m_upo = 1'b1;
        3'b100: m_mode = w[9];
        default: ;
      endcase
    endcase
  endfunction

  function automatic exp_t snap(string tag);
    exp_t e;
    e.a = m_out[0]; e.b = m_out[1];
    e.act = {~(m_sd[1] & pdl), ~(m_sd[0] & pdl)};
    e.upo = m_upo; e.mode = m_mode; e.tag = tag;
    return e;
  endfunction

  task automatic cmp(exp_t e);
    n_vec++;
    if (out_a !== e.a || out_b !== e.b || active !== e.act ||
        upo !== e.upo || mode !== e.mode) begin
      n_bad++;
      $display("FAIL %s: got a=%h b=%h act=%b upo=%b mode=%b exp a=%h b=%h act=%b upo=%b mode=%b",
               e.tag, out_a, out_b, active, upo, mode, e.a, e.b, e.act, e.upo, e.mode);
    end
  endtask

  task automatic send(logic [15:0] w, string tag);
    @(negedge clk);
    word = w; valid = 1'b1;
    model_apply(w);
    exp_q.push_back(snap(tag));
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic chk_now(string tag);
    cmp(snap(tag));
  endtask

  // monitor: result due one edge after the strobe
  initial forever begin
    @(posedge clk);
    if (valid === 1'b1) begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) cmp(exp_q.pop_front());
    end
  end

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    model_clear();
    #5;
    chk_now("R1 reset state");
    @(negedge clk); rst_ni = 1'b1;

    send(16'h2ABC, "R2 load staging A only");
    send(16'hB234, "R2 load staging B only");
    send(16'h8000, "R5 transfer both");
    send(16'h4111, "R3 load A with update");
    send(16'hDFFF, "R3 load B with update");
    send(16'h2055, "R2 staging A, outputs held");
    send(16'hE000, "R6 shutdown both");
    send(16'h0400, "R7 transfer A wakes A");
    send(16'h1800, "R8 shutdown A");
    send(16'h1400, "R7 transfer B wakes B");
    send(16'h8000, "R5 transfer both wakes");
    send(16'h1C00, "R8 shutdown B");

    @(negedge clk); pdl = 1'b0; #1;
    chk_now("R12 async wake on lockout");
    send(16'hE000, "R12 shutdown both ignored");
    send(16'h1800, "R12 shutdown A ignored");
    @(negedge clk); pdl = 1'b1;
    m_sd = '0;
    @(negedge clk); #1;
    chk_now("R12 stays active after lockout release");

    send(16'h0C00, "R9 upo high");
    send(16'h0800, "R9 upo low");
    send(16'h1200, "R10 mode rising");
    send(16'h1000, "R10 mode falling");
    send(16'h03FF, "R11 extended nop");
    @(negedge clk); word = 16'h6AAA; valid = 1'b0;
    @(negedge clk); #1;
    chk_now("R11 word without strobe ignored");

    send(16'h6F0F, "R4 direct load both");
    send(16'h2001, "R2 staging A after direct");
    send(16'h8000, "R4 staging B written by direct");

    send(16'h0C00, "R9 upo high before clear");
    send(16'h1200, "R10 mode high before clear");
    send(16'h1800, "R8 shutdown A before clear");
    @(negedge clk); clr_n = 1'b0; word = 16'h6123; valid = 1'b1;
    @(negedge clk); clr_n = 1'b1; valid = 1'b0;
    model_clear(); #1;
    chk_now("R1 clear overrides command");
    send(16'h8000, "R13 transfer after clear stays zero");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule